// File: doc/BRIEF.md
# Phase-timed ROM/RAM bus responder

This block is a slave on a shared, multiplexed bus whose bus cycle is cut into six named phases by an external phase tracker. In each bus cycle it can answer an instruction-fetch style ROM read and a nibble-wide RAM access. The two accesses are decoded at different points of the cycle, drive the data lines in different phase windows, and select on different rules. The block holds a 2048 x 8 read-only store and a 128 x 4 read/write store, both inferred as arrays.

Every action fires on the single system clock where the phase input differs from its value on the previous clock. Holding a phase therefore repeats nothing, however many system clocks the phase lasts. The drive output is the value the block wants on the data lines, and all zeros means the lines are released. Two sticky diagnostic flags report a mismatch between what the block drove and what it read back from the bus.

Top module: `rom_ram_responder`

## Requirements
- R1: The phase input uses the codes 0 idle, 1 P1A, 2 P1, 3 P2, 4 P3A, 5 P3, 6 P4, and the normal order is P1A, P1, P2, P3A, P3, P4. An action fires only on the clock where the phase code changes, so input changes while a phase is held have no effect on stored data or on the flags.
- R2: On entry to P3A the block latches address bits 10..0 as the ROM address. The ROM is selected for that cycle when the select line equals ROM_SEL (default 1).
- R3: When the ROM is selected, drive_o shows the ROM byte from entry to P4 until entry to P1, so the byte is still present through P1A. With the default parameters the byte at ROM address a is (a*37 + 0x5A) mod 256.
- R4: On entry to P1 and on entry to P3, drive_o becomes all zeros (released). When neither store is selected, drive_o stays zero.
- R5: On entry to P1A the block latches address bits 7..1 as the RAM address. The RAM is selected only if wio_i is 0, the select line equals RAM_SEL (default 0), and address bit 8 equals RAM_A8 (default 1).
- R6: When the RAM is selected, drive_o bits 3..0 show the stored nibble from entry to P2 until entry to P3, and bits 7..4 stay zero.
- R7: On entry to P3A, if the RAM was selected and wio_i is 1, data bits 7..4 are written at the latched RAM address.
- R8: On entry to P1A, if the ROM was selected in that bus cycle and din_i differs from drive_o, rom_fault_o is set.
- R9: On entry to P3A, if the RAM was selected and din_i bits 3..0 differ from drive_o bits 3..0, ram_fault_o is set. This applies to both reads and writes.
- R10: Reset clears drive_o and both flags. Once set, a flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the phase rate |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| phase_i | input | 3 | Current phase code from the phase tracker |
| addr_i | input | 12 | Address bus |
| din_i | input | 8 | Data lines as read from the bus |
| sel_i | input | 1 | ROM/RAM chip select line |
| wio_i | input | 1 | Write/IO qualifier line |
| drive_o | output | 8 | Value to drive on the data lines, zero when released |
| rom_fault_o | output | 1 | Sticky ROM read-back mismatch flag |
| ram_fault_o | output | 1 | Sticky RAM read-back mismatch flag |

## Verification
The stores are first filled by a write sweep over every RAM address, and the block is then reset. This reset leaves the contents in place and clears the flags that the sweep may have raised. Directed cycles cover the extreme ROM addresses 0 and 2047, the extreme RAM addresses 0 and 127, and a RAM miss caused by each of the three select conditions separately. One cycle selects both stores, which separates the low-nibble RAM window from the full-byte ROM window. Random cycles then mix select, address, write and data values, and each output is compared with a bench model after every phase. Read-back errors are injected both with and without the matching store selected, which shows that each flag has the right trigger and stays set. Every cycle also changes the data input while P3A is held, which would expose any action that fires more than once.

// File: rtl/rbr_pkg.sv
package rbr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_1A   = 3'd1,
    PH_1    = 3'd2,
    PH_2    = 3'd3,
    PH_3A   = 3'd4,
    PH_3    = 3'd5,
    PH_4    = 3'd6
  } phase_e;

  // Computed initial content of the read-only store.
  function automatic logic [7:0] rom_word(input int unsigned a, input logic [7:0] seed);
    logic [31:0] t;
    t = a * 32'd37 + 32'(seed);
    return t[7:0];
  endfunction

endpackage

// File: rtl/rbr_phase_edge.sv
module rbr_phase_edge
  import rbr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] phase_i,
  output phase_e     ph_o,
  output logic       step_o
);

  phase_e last_q;
  phase_e last_d;

  assign ph_o   = phase_e'(phase_i);
  assign step_o = (ph_o != last_q);

  always_comb begin
    last_d = ph_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= PH_IDLE;
    else         last_q <= last_d;
  end

endmodule

// File: rtl/rbr_rom_port.sv
module rbr_rom_port
  import rbr_pkg::*;
#(
  parameter int          ROM_AW   = 11,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  ROM_SEED = 8'h5A,
  parameter logic        ROM_SEL  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  phase_e            ph_i,
  input  logic [ROM_AW-1:0] addr_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] drv_o,
  output logic              fault_o
);

  localparam int DEPTH = 1 << ROM_AW;

  logic [DATA_W-1:0] rom_mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom_mem[g] = DATA_W'(rom_word(g, ROM_SEED));
  end

  logic [ROM_AW-1:0] addr_q, addr_d;
  logic              on_q, on_d;
  logic [DATA_W-1:0] drv_q, drv_d;
  logic              flt_q, flt_d;

  always_comb begin
    addr_d = addr_q;
    on_d   = on_q;
    drv_d  = drv_q;
    flt_d  = flt_q;
    if (step_i) begin
      unique case (ph_i)
        PH_3A: begin
          addr_d = addr_i;
          on_d   = (sel_i == ROM_SEL);
        end
        PH_4: if (on_q) drv_d = rom_mem[addr_q];
        PH_1A: begin
          if (on_q && (drv_q != din_i)) flt_d = 1'b1;
          on_d = 1'b0;
        end
        PH_1, PH_3: drv_d = '0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      on_q   <= 1'b0;
      drv_q  <= '0;
      flt_q  <= 1'b0;
    end else if (step_i) begin
      addr_q <= addr_d;
      on_q   <= on_d;
      drv_q  <= drv_d;
      flt_q  <= flt_d;
    end
  end

  assign drv_o   = drv_q;
  assign fault_o = flt_q;

endmodule

// File: rtl/rbr_ram_port.sv
module rbr_ram_port
  import rbr_pkg::*;
#(
  parameter int   RAM_AW  = 7,
  parameter int   NIB_W   = 4,
  parameter logic RAM_SEL = 1'b0,
  parameter logic RAM_A8  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  phase_e            ph_i,
  input  logic [RAM_AW:0]   addr_i,   // address bits RAM_AW+1 .. 1
  input  logic              sel_i,
  input  logic              wio_i,
  input  logic [2*NIB_W-1:0] din_i,
  output logic [NIB_W-1:0]  drv_o,
  output logic              fault_o
);

  localparam int DEPTH = 1 << RAM_AW;

  logic [NIB_W-1:0]  mem [DEPTH];
  logic [RAM_AW-1:0] addr_q, addr_d;
  logic              on_q, on_d;
  logic [NIB_W-1:0]  drv_q, drv_d;
  logic              flt_q, flt_d;
  logic              we;

  always_comb begin
    addr_d = addr_q;
    on_d   = on_q;
    drv_d  = drv_q;
    flt_d  = flt_q;
    we     = 1'b0;
    if (step_i) begin
      unique case (ph_i)
        PH_1A: begin
          addr_d = addr_i[RAM_AW-1:0];
          on_d   = !wio_i && (sel_i == RAM_SEL) && (addr_i[RAM_AW] == RAM_A8);
        end
        PH_2: if (on_q) drv_d = mem[addr_q];
        PH_3A: begin
          if (on_q) begin
            we = wio_i;
            if (drv_q != din_i[NIB_W-1:0]) flt_d = 1'b1;
          end
          on_d = 1'b0;
        end
        PH_1, PH_3: drv_d = '0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (we) mem[addr_q] <= din_i[2*NIB_W-1:NIB_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      on_q   <= 1'b0;
      drv_q  <= '0;
      flt_q  <= 1'b0;
    end else if (step_i) begin
      addr_q <= addr_d;
      on_q   <= on_d;
      drv_q  <= drv_d;
      flt_q  <= flt_d;
    end
  end

  assign drv_o   = drv_q;
  assign fault_o = flt_q;

endmodule

// File: rtl/rom_ram_responder.sv
module rom_ram_responder
  import rbr_pkg::*;
#(
  parameter int         ADDR_W   = 12,
  parameter int         DATA_W   = 8,
  parameter int         ROM_AW   = 11,
  parameter int         RAM_AW   = 7,
  parameter logic [7:0] ROM_SEED = 8'h5A,
  parameter logic       ROM_SEL  = 1'b1,
  parameter logic       RAM_SEL  = 1'b0,
  parameter logic       RAM_A8   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        phase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              sel_i,
  input  logic              wio_i,
  output logic [DATA_W-1:0] drive_o,
  output logic              rom_fault_o,
  output logic              ram_fault_o
);

  localparam int NIB_W = DATA_W / 2;

  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  phase_e           ph;
  logic             step;
  logic [DATA_W-1:0] rom_drv;
  logic [NIB_W-1:0]  ram_drv;
  logic              unused_addr;

  assign unused_addr = ^addr_i[ADDR_W-1:ROM_AW];

  rbr_phase_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .phase_i(phase_i),
    .ph_o   (ph),
    .step_o (step)
  );

  rbr_rom_port #(
    .ROM_AW  (ROM_AW),
    .DATA_W  (DATA_W),
    .ROM_SEED(ROM_SEED),
    .ROM_SEL (ROM_SEL)
  ) u_rom (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .step_i (step),
    .ph_i   (ph),
    .addr_i (addr_i[ROM_AW-1:0]),
    .sel_i  (sel_i),
    .din_i  (din_i),
    .drv_o  (rom_drv),
    .fault_o(rom_fault_o)
  );

  rbr_ram_port #(
    .RAM_AW (RAM_AW),
    .NIB_W  (NIB_W),
    .RAM_SEL(RAM_SEL),
    .RAM_A8 (RAM_A8)
  ) u_ram (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .step_i (step),
    .ph_i   (ph),
    .addr_i (addr_i[RAM_AW+1:1]),
    .sel_i  (sel_i),
    .wio_i  (wio_i),
    .din_i  (din_i),
    .drv_o  (ram_drv),
    .fault_o(ram_fault_o)
  );

  assign drive_o = rom_drv | {{(DATA_W-NIB_W){1'b0}}, ram_drv};

endmodule

// File: rtl/rbr_checker.sv
module rbr_checker
  import rbr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] phase,
  input logic [7:0] drive,
  input logic       rom_fault,
  input logic       ram_fault
);

  // R4
  released_in_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == PH_1 || $past(phase) == PH_3) |-> drive == 8'h00);

  // R10
  rom_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rom_fault) |-> rom_fault);

  // R10
  ram_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ram_fault) |-> ram_fault);

  // R8
  rom_flag_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rom_fault) |-> $past(phase) == PH_1A);

  // R9
  ram_flag_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_fault) |-> $past(phase) == PH_3A);

endmodule

bind rom_ram_responder rbr_checker u_chk (
  .clk      (clk_i),
  .rst_n    (rst_ni),
  .phase    (phase_i),
  .drive    (drive_o),
  .rom_fault(rom_fault_o),
  .ram_fault(ram_fault_o)
);

// File: tb/sim_rom_ram_responder.sv
module sim_rom_ram_responder;

  localparam logic       ROM_SEL = 1'b1;
  localparam logic       RAM_SEL = 1'b0;
  localparam logic       RAM_A8  = 1'b1;
  localparam logic [7:0] SEED    = 8'h5A;

  localparam logic [2:0] P1A = 3'd1, P1 = 3'd2, P2 = 3'd3, P3A = 3'd4, P3 = 3'd5, P4 = 3'd6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0]  phase = 3'd0;
  logic [11:0] addr = '0;
  logic [7:0]  din = '0;
  logic        sel = 1'b0;
  logic        wio = 1'b0;
  logic [7:0]  drive;
  logic        rom_fault, ram_fault;

  always #2 clk = ~clk;

  rom_ram_responder u0 (
    .clk_i(clk), .rst_ni(rst_n), .phase_i(phase), .addr_i(addr), .din_i(din),
    .sel_i(sel), .wio_i(wio), .drive_o(drive), .rom_fault_o(rom_fault), .ram_fault_o(ram_fault)
  );

  int total = 0;
  int bad = 0;
  bit init_mode = 0;

  logic [7:0]  m_drive = '0;
  bit          m_romf = 0, m_ramf = 0, m_rom_on = 0, m_ram_on = 0;
  logic [10:0] m_rom_a = '0;
  logic [6:0]  m_ram_a = '0;
  logic [3:0]  m_mem [128];

  function automatic logic [7:0] rom_fn(input logic [10:0] a);
    int unsigned t;
    t = int'(a) * 37 + int'(SEED);
    return t[7:0];
  endfunction

  task automatic check(input string tag);
    if (init_mode) return;
    total++;
    if (drive !== m_drive || rom_fault !== m_romf || ram_fault !== m_ramf) begin
      bad++;
      $display("FAIL %s: drive=%h romf=%b ramf=%b expected drive=%h romf=%b ramf=%b",
               tag, drive, rom_fault, ram_fault, m_drive, m_romf, m_ramf);
    end
  endtask

  task automatic enter(input logic [2:0] p);
    @(negedge clk);
    phase = p;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    phase = 3'd0;
    m_drive = '0; m_romf = 0; m_ramf = 0; m_rom_on = 0; m_ram_on = 0;
    repeat (3) @(negedge clk);
    check("R10 reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 after release");
  endtask

  task automatic do_cycle(input logic [11:0] a1a, input logic sel1a, input logic wio1a,
                          input logic [11:0] a3a, input logic sel3a, input logic wio3a,
                          input logic [3:0] wd, input logic [7:0] rom_err, input logic [3:0] ram_err);
    // P1A: RAM decode, ROM read-back check
    addr = a1a; sel = sel1a; wio = wio1a; din = m_drive ^ rom_err;
    if (m_rom_on && rom_err != 0) m_romf = 1;
    m_rom_on = 0;
    m_ram_a  = a1a[7:1];
    m_ram_on = !wio1a && (sel1a == RAM_SEL) && (a1a[8] == RAM_A8);
    enter(P1A);
    check("R3 R8 P1A");
    enter(P1); m_drive = '0; check("R4 P1");
    enter(P2); if (m_ram_on) m_drive[3:0] = m_mem[m_ram_a]; check("R5 R6 P2");
    // P3A: ROM decode, RAM write and read-back check
    addr = a3a; sel = sel3a; wio = wio3a; din = {wd, m_drive[3:0] ^ ram_err};
    if (m_ram_on) begin
      if (ram_err != 0) m_ramf = 1;
      if (wio3a) m_mem[m_ram_a] = wd;
    end
    m_ram_on = 0;
    m_rom_a  = a3a[10:0];
    m_rom_on = (sel3a == ROM_SEL);
    enter(P3A);
    check("R7 R9 P3A");
    din = ~din;                       // R1: must be ignored while P3A is held
    repeat (2) @(negedge clk);
    check("R1 held phase");
    enter(P3); m_drive = '0; check("R4 P3");
    enter(P4); if (m_rom_on) m_drive = rom_fn(m_rom_a); check("R2 R3 P4");
    @(negedge clk);
  endtask

  function automatic logic [11:0] ram_addr(input logic [6:0] a, input logic a8);
    return {3'b000, a8, a, 1'b0};
  endfunction

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 128; i++) m_mem[i] = '0;
    do_reset();

    // Fill the RAM, then reset to discard flags raised on unknown contents.
    init_mode = 1;
    for (int i = 0; i < 128; i++)
      do_cycle(ram_addr(7'(i), RAM_A8), RAM_SEL, 1'b0, 12'h000, ~ROM_SEL, 1'b1,
               4'(i) ^ 4'(i >> 3), 8'h00, 4'h0);
    init_mode = 0;
    do_reset();

    // Directed corners
    do_cycle(12'h000, ~RAM_SEL, 1'b0, 12'h000, ROM_SEL, 1'b0, 4'h0, 8'h00, 4'h0); // R2 ROM addr 0
    do_cycle(12'h000, ~RAM_SEL, 1'b0, 12'hFFF, ROM_SEL, 1'b0, 4'h0, 8'h00, 4'h0); // R2 ROM addr 2047
    do_cycle(ram_addr(7'd0, RAM_A8), RAM_SEL, 1'b0, 12'h000, ~ROM_SEL, 1'b0, 4'h0, 8'h00, 4'h0);   // R6 RAM addr 0
    do_cycle(ram_addr(7'd127, RAM_A8), RAM_SEL, 1'b0, 12'h000, ~ROM_SEL, 1'b0, 4'h0, 8'h00, 4'h0); // R6 RAM addr 127
    do_cycle(ram_addr(7'd5, ~RAM_A8), RAM_SEL, 1'b0, 12'h000, ~ROM_SEL, 1'b1, 4'hF, 8'h00, 4'h0);  // R5 wrong bit 8
    do_cycle(ram_addr(7'd5, RAM_A8), ~RAM_SEL, 1'b0, 12'h000, ~ROM_SEL, 1'b1, 4'hF, 8'h00, 4'h0);  // R5 wrong select
    do_cycle(ram_addr(7'd5, RAM_A8), RAM_SEL, 1'b1, 12'h000, ~ROM_SEL, 1'b1, 4'hF, 8'h00, 4'h0);   // R5 wio high
    do_cycle(ram_addr(7'd5, RAM_A8), RAM_SEL, 1'b0, 12'h000, ~ROM_SEL, 1'b1, 4'h9, 8'h00, 4'h0);   // R7 write
    do_cycle(ram_addr(7'd5, RAM_A8), RAM_SEL, 1'b0, 12'h3C1, ROM_SEL, 1'b0, 4'h0, 8'h00, 4'h0);    // R7 readback, both stores

    // Random traffic
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      logic [11:0] a1, a3;
      r  = $urandom;
      a1 = 12'($urandom);
      a3 = 12'($urandom);
      if (r[0]) a1[8] = RAM_A8;
      do_cycle(a1, r[1] ? RAM_SEL : r[9], r[2] & r[3], a3, r[4], r[5], r[11:8], 8'h00, 4'h0);
    end

    // Read-back faults
    do_reset();
    do_cycle(12'h000, ~RAM_SEL, 1'b0, 12'h010, ~ROM_SEL, 1'b0, 4'h0, 8'h00, 4'h0);
    do_cycle(12'h000, ~RAM_SEL, 1'b0, 12'h020, ROM_SEL, 1'b0, 4'h0, 8'h44, 4'h0);  // R8 not selected: no flag
    do_cycle(12'h000, ~RAM_SEL, 1'b0, 12'h000, ~ROM_SEL, 1'b0, 4'h0, 8'h01, 4'h0); // R8 selected: flag
    do_cycle(12'h000, ~RAM_SEL, 1'b0, 12'h000, ~ROM_SEL, 1'b0, 4'h0, 8'h00, 4'h0); // R10 sticky
    do_reset();
    do_cycle(ram_addr(7'd9, RAM_A8), ~RAM_SEL, 1'b0, 12'h000, ~ROM_SEL, 1'b0, 4'h0, 8'h00, 4'h6); // R9 no flag
    do_cycle(ram_addr(7'd9, RAM_A8), RAM_SEL, 1'b1, 12'h000, ~ROM_SEL, 1'b1, 4'h3, 8'h00, 4'h0);  // R9 wio miss
    do_cycle(ram_addr(7'd9, RAM_A8), RAM_SEL, 1'b0, 12'h000, ~ROM_SEL, 1'b1, 4'h3, 8'h00, 4'h8);  // R9 flag on write
    do_cycle(ram_addr(7'd9, RAM_A8), RAM_SEL, 1'b0, 12'h000, ~ROM_SEL, 1'b0, 4'h0, 8'h00, 4'h0);  // R10 sticky, R7 data
    do_reset();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule